// File: doc/BRIEF.md
# Subheader Sequence Rule Checker for Wireless MAC Frames

This block validates the opening of a wireless MAC protocol data unit once an upstream parser has already split it into tokens. Tokens arrive one per cycle on a valid/ready stream. A header token gives the header type bit. A class token names the connection class the frame travels on. Subheader tokens follow, one type code each, and an end token closes the frame. The block keeps a small amount of per-frame state. When the end token is accepted it produces a one-cycle verdict: a pass flag and a 3-bit error code.

The checks cover four areas. A bandwidth-request header may carry nothing after it. Subheaders have placement rules: mesh comes first, grant management precedes fragmentation, and fast-feedback comes last. Packing and fragmentation exclude each other. The three restricted management connection classes may use neither packing nor fragmentation. A subheader type may also not appear twice. When several rules fail, the smallest error code wins. All frame state is wiped when a frame ends, so frames can follow each other with no idle cycle between them.

Top module: `pdu_subhdr_check`

## Requirements
- R1: Token encoding on `tok_kind` is 0 for header (the header type bit is `tok_data[0]`), 1 for class (the class is `tok_data[1:0]`), 2 for subheader (the type code is `tok_data[2:0]`) and 3 for end. A token is accepted when `tok_valid` and `tok_ready` are both high. `tok_ready` is high whenever reset is low.
- R2: In the cycle after an end token is accepted, `res_valid` is high for exactly one cycle. `res_pass` is 1 exactly when `res_code` is 0. At no other time is `res_valid` high.
- R3: A header type bit of 1 marks a bandwidth-request header. If any subheader token (any code) is accepted in that frame, the code is 1. With no subheader tokens, the frame passes.
- R4: Subheader type codes are: mesh 0, grant management 1, fragmentation 2, packing 3, fast-feedback 4. A mesh subheader that follows any other known subheader gives code 2.
- R5: A grant-management subheader that follows a fragmentation subheader gives code 3. Grant management before fragmentation is legal.
- R6: Packing and fragmentation in the same frame give code 4.
- R7: Any known subheader after a fast-feedback subheader gives code 5.
- R8: Connection classes are basic 0, broadcast 1, initial ranging 2 and primary management 3. On classes 0 to 2, packing or fragmentation gives code 6. Class 3 allows both.
- R9: A known subheader type that appears a second time in a frame gives code 7.
- R10: When several rules fail, the lowest error code is reported.
- R11: Accepting the end token clears the frame state. If a frame has no header or class token, its header type is 0 and its class is 0. Consecutive frames are judged independently.
- R12: In a frame with header type 0, subheader codes 5 to 7 have no effect on the verdict or on the placement rules.
- R13: During synchronous reset `res_valid` and `tok_ready` are low, and the frame state is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Block accepts a token |
| tok_kind | input | 2 | Token kind: header, class, subheader, end |
| tok_data | input | 3 | Token payload |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_pass | output | 1 | Frame obeyed every rule |
| res_code | output | 3 | Lowest violated rule code, 0 when clean |

## Verification
Every verdict is due exactly one cycle after its end token is accepted, because one register stage lies between the rule logic and the outputs. The driver sends tokens just after a rising edge. For each frame it pushes the expected code into a queue when the end token is sent. The monitor samples on the falling edge that follows, so each verdict is compared in its own cycle against the oldest queued entry. A strobe that arrives with the queue empty counts as a failure, and so does a code that does not match the entry it is compared against.

// File: rtl/pdu_chk_pkg.sv
package pdu_chk_pkg;

  localparam int KIND_W  = 2;
  localparam int CODE_W  = 3;
  localparam int CLASS_W = 2;
  localparam int NUM_SUB = 5;
  localparam int ERR_W   = 3;
  localparam int NUM_ERR = (1 << ERR_W) - 1;

  localparam logic [KIND_W-1:0] TK_HDR   = 2'd0;
  localparam logic [KIND_W-1:0] TK_CLASS = 2'd1;
  localparam logic [KIND_W-1:0] TK_SUB   = 2'd2;
  localparam logic [KIND_W-1:0] TK_END   = 2'd3;

  localparam int SH_MESH  = 0;
  localparam int SH_GRANT = 1;
  localparam int SH_FRAG  = 2;
  localparam int SH_PACK  = 3;
  localparam int SH_FFB   = 4;

  localparam logic [CLASS_W-1:0] CL_PRIMARY = 2'd3;

  localparam int E_BW_PAYLOAD = 1;
  localparam int E_MESH_POS   = 2;
  localparam int E_GRANT_POS  = 3;
  localparam int E_PACK_FRAG  = 4;
  localparam int E_FFB_POS    = 5;
  localparam int E_CLASS      = 6;
  localparam int E_DUP        = 7;

  function automatic logic class_restricted(input logic [CLASS_W-1:0] cls);
    return cls != CL_PRIMARY;
  endfunction

  function automatic logic sub_known(input logic [CODE_W-1:0] code);
    return int'(code) < NUM_SUB;
  endfunction

  // Lowest set rule index wins; 0 when the vector is clear.
  function automatic logic [ERR_W-1:0] first_error(input logic [NUM_ERR:1] v);
    logic [ERR_W-1:0] r;
    r = '0;
    for (int i = NUM_ERR; i >= 1; i--) begin
      if (v[i]) r = ERR_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/pdu_hdr_latch.sv
module pdu_hdr_latch
  import pdu_chk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               ht_we,
  input  logic               ht_in,
  input  logic               cls_we,
  input  logic [CLASS_W-1:0] cls_in,
  output logic               ht_q,
  output logic [CLASS_W-1:0] cls_q
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ht_q  <= 1'b0;
      cls_q <= '0;
    end else begin
      if (ht_we)  ht_q  <= ht_in;
      if (cls_we) cls_q <= cls_in;
    end
  end

endmodule

// File: rtl/pdu_sub_tracker.sv
module pdu_sub_tracker
  import pdu_chk_pkg::*;
#(
  parameter int N_TYPES = NUM_SUB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              sub_fire,
  input  logic [CODE_W-1:0] sub_code,
  output logic [N_TYPES-1:0] seen,
  output logic              any_tok,
  output logic              any_known,
  output logic              mesh_late,
  output logic              grant_late,
  output logic              ffb_late,
  output logic              dup_hit
);

  logic [N_TYPES-1:0] hit;
  logic               known;

  assign known = sub_fire && sub_known(sub_code);

  genvar g;
  generate
    for (g = 0; g < N_TYPES; g++) begin : g_type
      assign hit[g] = sub_fire && (sub_code == CODE_W'(g));
      always_ff @(posedge clk) begin
        if (rst || clr)  seen[g] <= 1'b0;
        else if (hit[g]) seen[g] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      any_tok    <= 1'b0;
      any_known  <= 1'b0;
      mesh_late  <= 1'b0;
      grant_late <= 1'b0;
      ffb_late   <= 1'b0;
      dup_hit    <= 1'b0;
    end else begin
      if (sub_fire) any_tok <= 1'b1;
      if (known) begin
        any_known <= 1'b1;
        if (hit[SH_MESH] && any_known)     mesh_late  <= 1'b1;
        if (hit[SH_GRANT] && seen[SH_FRAG]) grant_late <= 1'b1;
        if (seen[SH_FFB])                   ffb_late   <= 1'b1;
        if (|(hit & seen))                  dup_hit    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pdu_verdict.sv
module pdu_verdict
  import pdu_chk_pkg::*;
#(
  parameter int N_TYPES = NUM_SUB
) (
  input  logic               ht,
  input  logic [CLASS_W-1:0] cls,
  input  logic [N_TYPES-1:0] seen,
  input  logic               any_tok,
  input  logic               mesh_late,
  input  logic               grant_late,
  input  logic               ffb_late,
  input  logic               dup_hit,
  output logic [NUM_ERR:1]   err_vec,
  output logic [ERR_W-1:0]   code,
  output logic               pass
);

  always_comb begin
    err_vec               = '0;
    err_vec[E_BW_PAYLOAD] = ht && any_tok;
    err_vec[E_MESH_POS]   = mesh_late;
    err_vec[E_GRANT_POS]  = grant_late;
    err_vec[E_PACK_FRAG]  = seen[SH_PACK] && seen[SH_FRAG];
    err_vec[E_FFB_POS]    = ffb_late;
    err_vec[E_CLASS]      = class_restricted(cls) && (seen[SH_PACK] || seen[SH_FRAG]);
    err_vec[E_DUP]        = dup_hit;
  end

  assign code = first_error(err_vec);
  assign pass = (err_vec == '0);

endmodule

// File: rtl/pdu_subhdr_check.sv
module pdu_subhdr_check
  import pdu_chk_pkg::*;
#(
  parameter int DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [KIND_W-1:0] tok_kind,
  input  logic [DATA_W-1:0] tok_data,
  output logic              res_valid,
  output logic              res_pass,
  output logic [ERR_W-1:0]  res_code
);

  localparam int N_TYPES = NUM_SUB;

  logic               tok_fire;
  logic               end_fire;
  logic               sub_fire;
  logic [CODE_W-1:0]  sub_code;
  logic               ht_q;
  logic [CLASS_W-1:0] cls_q;
  logic [N_TYPES-1:0] seen;
  logic               any_tok;
  logic               any_known;
  logic               mesh_late;
  logic               grant_late;
  logic               ffb_late;
  logic               dup_hit;
  logic [NUM_ERR:1]   err_vec;
  logic [ERR_W-1:0]   verdict_code;
  logic               verdict_pass;

  assign tok_ready = ~rst;
  assign tok_fire  = tok_valid && tok_ready;
  assign end_fire  = tok_fire && (tok_kind == TK_END);
  assign sub_fire  = tok_fire && (tok_kind == TK_SUB);
  assign sub_code  = tok_data[CODE_W-1:0];

  pdu_hdr_latch u_hdr (
    .clk    (clk),
    .rst    (rst),
    .clr    (end_fire),
    .ht_we  (tok_fire && (tok_kind == TK_HDR)),
    .ht_in  (tok_data[0]),
    .cls_we (tok_fire && (tok_kind == TK_CLASS)),
    .cls_in (tok_data[CLASS_W-1:0]),
    .ht_q   (ht_q),
    .cls_q  (cls_q)
  );

  pdu_sub_tracker #(.N_TYPES(N_TYPES)) u_trk (
    .clk        (clk),
    .rst        (rst),
    .clr        (end_fire),
    .sub_fire   (sub_fire),
    .sub_code   (sub_code),
    .seen       (seen),
    .any_tok    (any_tok),
    .any_known  (any_known),
    .mesh_late  (mesh_late),
    .grant_late (grant_late),
    .ffb_late   (ffb_late),
    .dup_hit    (dup_hit)
  );

  pdu_verdict #(.N_TYPES(N_TYPES)) u_vrd (
    .ht         (ht_q),
    .cls        (cls_q),
    .seen       (seen),
    .any_tok    (any_tok),
    .mesh_late  (mesh_late),
    .grant_late (grant_late),
    .ffb_late   (ffb_late),
    .dup_hit    (dup_hit),
    .err_vec    (err_vec),
    .code       (verdict_code),
    .pass       (verdict_pass)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
      res_code  <= '0;
    end else begin
      res_valid <= end_fire;
      if (end_fire) begin
        res_pass <= verdict_pass;
        res_code <= verdict_code;
      end
    end
  end

endmodule

// File: rtl/pdu_subhdr_check_sva.sv
module pdu_subhdr_check_sva
  import pdu_chk_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              end_fire,
  input logic              sub_fire,
  input logic [CODE_W-1:0] sub_code,
  input logic              any_known,
  input logic              any_tok,
  input logic              ht_q,
  input logic [NUM_ERR:1]  err_vec,
  input logic              res_valid,
  input logic              res_pass,
  input logic [ERR_W-1:0]  res_code
);

  p_result_due_r2: assert property (@(posedge clk) disable iff (rst)
    end_fire |=> res_valid);

  p_no_stray_r2: assert property (@(posedge clk) disable iff (rst)
    !end_fire |=> !res_valid);

  p_pass_code_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_pass == (res_code == '0)));

  p_bw_payload_r3: assert property (@(posedge clk) disable iff (rst)
    (end_fire && ht_q && any_tok) |=> (res_code == ERR_W'(E_BW_PAYLOAD)));

  p_mesh_late_r4: assert property (@(posedge clk) disable iff (rst)
    (sub_fire && sub_code == CODE_W'(SH_MESH) && any_known) |=> err_vec[E_MESH_POS]);

  p_lowest_r10: assert property (@(posedge clk) disable iff (rst)
    (end_fire && err_vec[E_DUP] && err_vec[E_FFB_POS]) |=> (res_code <= ERR_W'(E_FFB_POS)));

  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    end_fire |=> (!any_tok && !any_known && !ht_q && err_vec == '0));

endmodule

bind pdu_subhdr_check pdu_subhdr_check_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .end_fire  (end_fire),
  .sub_fire  (sub_fire),
  .sub_code  (sub_code),
  .any_known (any_known),
  .any_tok   (any_tok),
  .ht_q      (ht_q),
  .err_vec   (err_vec),
  .res_valid (res_valid),
  .res_pass  (res_pass),
  .res_code  (res_code)
);

// File: tb/pdu_subhdr_check_test.sv
module pdu_subhdr_check_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tok_valid = 1'b0;
  logic       tok_ready;
  logic [1:0] tok_kind = 2'd0;
  logic [2:0] tok_data = 3'd0;
  logic       res_valid;
  logic       res_pass;
  logic [2:0] res_code;

  int checks = 0;
  int errors = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pdu_subhdr_check uut (
    .clk       (clk),
    .rst       (rst),
    .tok_valid (tok_valid),
    .tok_ready (tok_ready),
    .tok_kind  (tok_kind),
    .tok_data  (tok_data),
    .res_valid (res_valid),
    .res_pass  (res_pass),
    .res_code  (res_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] kind, input logic [2:0] data);
    tok_valid = 1'b1;
    tok_kind  = kind;
    tok_data  = data;
    @(posedge clk);
    #1;
    tok_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Frame driver: subheader i sits at subs[3*i +: 3].
  task automatic frame(input bit use_hdr, input logic ht, input bit use_cls,
                       input logic [1:0] cls, input logic [23:0] subs, input int n,
                       input logic [2:0] exp, input string req);
    if (use_hdr) send(2'd0, {2'b00, ht});
    if (use_cls) send(2'd1, {1'b0, cls});
    for (int i = 0; i < n; i++) send(2'd2, subs[3*i +: 3]);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    send(2'd3, 3'd0);
  endtask

  // Monitor: verdicts are compared in the cycle they appear.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 stray strobe", 1, 0);
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(res_code == e, t, res_code, e);
        check(res_pass == (e == 3'd0), "R2 pass flag", res_pass, (e == 3'd0));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(res_valid == 1'b0, "R13 res_valid in reset", res_valid, 0);
    check(tok_ready == 1'b0, "R13 ready in reset", tok_ready, 0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    check(tok_ready == 1'b1, "R1 ready after reset", tok_ready, 1);
    check(res_valid == 1'b0, "R2 idle after reset", res_valid, 0);
    @(posedge clk);
    #1;

    // Codes: mesh 0, grant 1, frag 2, pack 3, fast-feedback 4.
    frame(1, 0, 1, 2'd3, 24'h0, 0, 3'd0, "R2 empty generic frame");
    frame(1, 0, 1, 2'd3, {12'h0, 3'd4, 3'd2, 3'd1, 3'd0}, 4, 3'd0, "R5 legal order");
    frame(1, 1, 1, 2'd3, 24'h0, 0, 3'd0, "R3 bare bandwidth request");
    frame(1, 1, 1, 2'd3, {21'h0, 3'd4}, 1, 3'd1, "R3 subheader after bw header");
    frame(1, 1, 1, 2'd3, {21'h0, 3'd6}, 1, 3'd1, "R3 unknown code after bw header");
    frame(1, 0, 1, 2'd3, {18'h0, 3'd0, 3'd1}, 2, 3'd2, "R4 mesh not first");
    frame(1, 0, 1, 2'd3, {18'h0, 3'd1, 3'd2}, 2, 3'd3, "R5 grant after frag");
    frame(1, 0, 1, 2'd3, {18'h0, 3'd2, 3'd3}, 2, 3'd4, "R6 pack with frag");
    frame(1, 0, 1, 2'd3, {18'h0, 3'd1, 3'd4}, 2, 3'd5, "R7 fast-feedback not last");
    frame(1, 0, 1, 2'd0, {21'h0, 3'd3}, 1, 3'd6, "R8 pack on basic");
    frame(1, 0, 1, 2'd1, {21'h0, 3'd2}, 1, 3'd6, "R8 frag on broadcast");
    frame(1, 0, 1, 2'd2, {18'h0, 3'd4, 3'd1}, 2, 3'd0, "R8 ranging without pack/frag");
    frame(1, 0, 1, 2'd3, {21'h0, 3'd3}, 1, 3'd0, "R8 pack on primary");
    frame(1, 0, 1, 2'd3, {18'h0, 3'd1, 3'd1}, 2, 3'd7, "R9 duplicate grant");
    frame(1, 0, 1, 2'd3, {18'h0, 3'd4, 3'd4}, 2, 3'd5, "R10 ffb dup picks 5");
    frame(1, 0, 1, 2'd0, {15'h0, 3'd3, 3'd1, 3'd2}, 3, 3'd3, "R10 codes 3,4,6 pick 3");
    frame(1, 0, 1, 2'd3, {12'h0, 3'd4, 3'd7, 3'd0, 3'd5}, 4, 3'd0, "R12 unknown codes ignored");
    frame(1, 0, 1, 2'd3, {21'h0, 3'd1}, 1, 3'd0, "R11 fresh frame after dup");
    frame(1, 1, 1, 2'd3, 24'h0, 0, 3'd0, "R11 bw frame before default");
    frame(0, 0, 0, 2'd0, {21'h0, 3'd3}, 1, 3'd6, "R11 defaults ht0 class0");

    // Idle gap inside a frame and tokens in swapped order.
    send(2'd1, 3'd3);
    idle(2);
    send(2'd0, 3'd0);
    send(2'd2, 3'd3);
    idle(1);
    exp_q.push_back(3'd0);
    tag_q.push_back("R1 gaps and order");
    send(2'd3, 3'd0);

    idle(4);
    check(exp_q.size() == 0, "R2 all verdicts seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule